// File: doc/BRIEF.md
# Periodic Multi-Lane SPI Master

This block is a serial peripheral interface master that runs one full-duplex frame per sample period, without any request from outside. A free-running base step counter divides the system clock into steps; every `STEPS_PER_FRAME` steps a start tick fires and, if the engine is idle, a frame begins. The frame length is therefore tied to a whole number of base steps. With one step per frame the whole exchange must fit inside a single step. With several steps per frame it may stretch across them, and the received data still changes only once per period.

Any number of data lanes share one serial clock and one active-low chip select. Each lane shifts out `WORDS` words of `WORD_W` bits on its own MOSI line and captures the same number of bits from its own MISO line during the same frame. Clock polarity and phase are inputs, so all four SPI modes are available. Two delays are also inputs: one counts cycles from chip-select assertion to the first clock activity, and the other counts cycles from the last clock edge to chip-select release. Transmit words are taken from a parallel bus at the start tick. All received words appear together on a parallel bus with a one-cycle valid pulse. A flag pulses when a start tick arrives before the previous frame has ended.

Top module: `periodic_spi_master`

## Requirements
- R1: Start ticks are `P = STEP_CYCLES*STEPS_PER_FRAME` clock edges apart. Counting the rising edges at which `enable` is high from 0, a tick falls on every edge numbered `P-1` modulo P. An idle engine that sees a tick drives `cs_n` low right after that edge.
- R2: After `cs_n` falls, `sck` stays at its idle level for `cfg_cs_lead+1` cycles. It then toggles every `SCK_HALF` cycles, for exactly `2*WORDS*WORD_W` toggles.
- R3: After the last toggle, `cs_n` stays low for a further `cfg_clk_delay+1` cycles and then rises. Whenever `cs_n` is high, `sck` equals `cfg_cpol`.
- R4: A leading edge is one that moves `sck` away from `cfg_cpol`. With `cfg_cpha=0`, MISO is sampled on leading edges and MOSI changes on trailing edges, with the first bit driven from chip-select assertion. With `cfg_cpha=1`, MOSI changes on every leading edge after the first and MISO is sampled on trailing edges. Bits go MSB first.
- R5: Lane `l` uses bits `[l*WORDS*WORD_W +: WORDS*WORD_W]` of both `tx_data` and `rx_data`. Within a lane slice, the most significant word is sent and received first. All lanes shift on the same edges.
- R6: The frame is full duplex. When a frame ends, `rx_data` takes every lane's captured bits, and `rx_valid` is high for one cycle, in the first cycle that `cs_n` is high again.
- R7: `tx_data` is latched at the start tick. Changes made while a frame runs appear only in the next frame.
- R8: If the peer uses a different clock phase, the received words differ from the words the peer sent.
- R9: A start tick that arrives while a frame is still running is dropped, and `overrun` is high for one cycle right after that tick.
- R10: `rx_data` changes only in a cycle where `rx_valid` is high, so it updates at most once per frame period.
- R11: While `enable` is low, no frame starts, and the step counters restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the step counters; low holds them at zero |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_cs_lead | input | DLY_W | Extra cycles between chip-select assertion and clock start |
| cfg_clk_delay | input | DLY_W | Extra cycles between the last clock edge and chip-select release |
| tx_data | input | LANES*WORDS*WORD_W | Transmit words for all lanes |
| miso | input | LANES | Serial input, one bit per lane |
| sck | output | 1 | Shared serial clock |
| cs_n | output | 1 | Shared active-low chip select |
| mosi | output | LANES | Serial output, one bit per lane |
| rx_data | output | LANES*WORDS*WORD_W | Received words for all lanes |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` has been refreshed |
| overrun | output | 1 | One-cycle pulse when a start tick is dropped |

## Verification
The assertions assume that `cfg_cpol`, `cfg_cpha` and both delay inputs stay fixed from reset release until the next reset. They also assume that every frame lasts at least two cycles, which holds for any setting. The stimulus changes configuration only while reset is held. It drives `tx_data` and `miso` only on the falling clock edge. It models the peer as a device that reacts to `sck` transitions half a cycle after they occur. One scenario deliberately makes the frame longer than the period, to trigger the dropped-tick pulse.

// File: rtl/pspi_pkg.sv
package pspi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } seq_state_e;

endpackage

// File: rtl/pspi_tick_gen.sv
module pspi_tick_gen #(
    parameter int STEP_CYCLES     = 40,
    parameter int STEPS_PER_FRAME = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    localparam int SW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam int PW = (STEPS_PER_FRAME > 1) ? $clog2(STEPS_PER_FRAME) : 1;
    localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CYCLES - 1);
    localparam logic [PW-1:0] PER_LAST  = PW'(STEPS_PER_FRAME - 1);

    typedef struct packed {
        logic [SW-1:0] step;
        logic [PW-1:0] per;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     step_end;

    always_comb begin
        st_d     = st_q;
        step_end = (st_q.step == STEP_LAST);
        tick     = enable && step_end && (st_q.per == PER_LAST);
        if (!enable) begin
            st_d.step = '0;
            st_d.per  = '0;
        end else if (step_end) begin
            st_d.step = '0;
            st_d.per  = (st_q.per == PER_LAST) ? '0 : st_q.per + 1'b1;
        end else begin
            st_d.step = st_q.step + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pspi_seq.sv
module pspi_seq
    import pspi_pkg::*;
#(
    parameter int BITS     = 32,
    parameter int SCK_HALF = 2,
    parameter int DLY_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic [DLY_W-1:0] cfg_cs_lead,
    input  logic [DLY_W-1:0] cfg_clk_delay,
    output logic             load,
    output logic             shift_en,
    output logic             sample_en,
    output logic             finish,
    output logic             sck,
    output logic             cs_n,
    output logic             done,
    output logic             overrun
);
    localparam int EDGES = 2 * BITS;
    localparam int EW    = $clog2(EDGES);
    localparam int HW    = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [HW-1:0] HALF_LAST = HW'(SCK_HALF - 1);
    localparam logic [EW-1:0] EDGE_LAST = EW'(EDGES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [DLY_W-1:0] cnt;
        logic [HW-1:0]    hc;
        logic [EW-1:0]    eidx;
        logic             phase;
        logic             cs_n;
        logic             done;
        logic             overrun;
    } seq_st_t;

    localparam seq_st_t SEQ_RESET = '{
        state: ST_IDLE, cnt: '0, hc: '0, eidx: '0,
        phase: 1'b0, cs_n: 1'b1, done: 1'b0, overrun: 1'b0
    };

    seq_st_t st_d, st_q;
    logic    edge_now;
    logic    odd_edge;

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.overrun = tick && (st_q.state != ST_IDLE);
        load         = tick && (st_q.state == ST_IDLE);
        edge_now     = (st_q.state == ST_SHIFT) && (st_q.hc == HALF_LAST);
        odd_edge     = st_q.eidx[0];
        finish       = (st_q.state == ST_TRAIL) && (st_q.cnt == cfg_clk_delay);
        if (cfg_cpha) begin
            shift_en  = edge_now && !odd_edge && (st_q.eidx != '0);
            sample_en = edge_now && odd_edge;
        end else begin
            shift_en  = edge_now && odd_edge && (st_q.eidx != EDGE_LAST);
            sample_en = edge_now && !odd_edge;
        end

        unique case (st_q.state)
            ST_IDLE: begin
                st_d.phase = 1'b0;
                if (tick) begin
                    st_d.state = ST_LEAD;
                    st_d.cnt   = '0;
                    st_d.cs_n  = 1'b0;
                end
            end
            ST_LEAD: begin
                if (st_q.cnt == cfg_cs_lead) begin
                    st_d.state = ST_SHIFT;
                    st_d.hc    = '0;
                    st_d.eidx  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (edge_now) begin
                    st_d.hc    = '0;
                    st_d.phase = ~st_q.phase;
                    st_d.eidx  = st_q.eidx + 1'b1;
                    if (st_q.eidx == EDGE_LAST) begin
                        st_d.state = ST_TRAIL;
                        st_d.cnt   = '0;
                    end
                end else begin
                    st_d.hc = st_q.hc + 1'b1;
                end
            end
            ST_TRAIL: begin
                if (finish) begin
                    st_d.state = ST_IDLE;
                    st_d.cs_n  = 1'b1;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_RESET;
        else        st_q <= st_d;
    end

    assign sck     = cfg_cpol ^ st_q.phase;
    assign cs_n    = st_q.cs_n;
    assign done    = st_q.done;
    assign overrun = st_q.overrun;
endmodule

// File: rtl/pspi_lane.sv
module pspi_lane #(
    parameter int BITS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] load_word,
    input  logic            shift_en,
    input  logic            sample_en,
    input  logic            finish,
    input  logic            miso,
    output logic            mosi,
    output logic [BITS-1:0] rx_word
);
    typedef struct packed {
        logic [BITS-1:0] tx_sr;
        logic [BITS-1:0] rx_sr;
        logic [BITS-1:0] rx_word;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)
            st_d.tx_sr = load_word;
        else if (shift_en)
            st_d.tx_sr = {st_q.tx_sr[BITS-2:0], 1'b0};
        if (sample_en)
            st_d.rx_sr = {st_q.rx_sr[BITS-2:0], miso};
        if (finish)
            st_d.rx_word = st_q.rx_sr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mosi    = st_q.tx_sr[BITS-1];
    assign rx_word = st_q.rx_word;
endmodule

// File: rtl/periodic_spi_master.sv
module periodic_spi_master #(
    parameter int LANES           = 2,
    parameter int WORDS           = 2,
    parameter int WORD_W          = 16,
    parameter int STEP_CYCLES     = 40,
    parameter int STEPS_PER_FRAME = 4,
    parameter int SCK_HALF        = 2,
    parameter int DLY_W           = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            enable,
    input  logic                            cfg_cpol,
    input  logic                            cfg_cpha,
    input  logic [DLY_W-1:0]                cfg_cs_lead,
    input  logic [DLY_W-1:0]                cfg_clk_delay,
    input  logic [LANES*WORDS*WORD_W-1:0]   tx_data,
    input  logic [LANES-1:0]                miso,
    output logic                            sck,
    output logic                            cs_n,
    output logic [LANES-1:0]                mosi,
    output logic [LANES*WORDS*WORD_W-1:0]   rx_data,
    output logic                            rx_valid,
    output logic                            overrun
);
    localparam int BITS = WORDS * WORD_W;

    logic tick, load, shift_en, sample_en, finish;

    pspi_tick_gen #(
        .STEP_CYCLES    (STEP_CYCLES),
        .STEPS_PER_FRAME(STEPS_PER_FRAME)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(enable),
        .tick  (tick)
    );

    pspi_seq #(
        .BITS    (BITS),
        .SCK_HALF(SCK_HALF),
        .DLY_W   (DLY_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .cfg_cpol     (cfg_cpol),
        .cfg_cpha     (cfg_cpha),
        .cfg_cs_lead  (cfg_cs_lead),
        .cfg_clk_delay(cfg_clk_delay),
        .load         (load),
        .shift_en     (shift_en),
        .sample_en    (sample_en),
        .finish       (finish),
        .sck          (sck),
        .cs_n         (cs_n),
        .done         (rx_valid),
        .overrun      (overrun)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        pspi_lane #(.BITS(BITS)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .load_word(tx_data[l*BITS +: BITS]),
            .shift_en (shift_en),
            .sample_en(sample_en),
            .finish   (finish),
            .miso     (miso[l]),
            .mosi     (mosi[l]),
            .rx_word  (rx_data[l*BITS +: BITS])
        );
    end
endmodule

// File: rtl/pspi_checker.sv
module pspi_checker #(
    parameter int RX_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_cpol,
    input logic            cs_n,
    input logic            sck,
    input logic            rx_valid,
    input logic            overrun,
    input logic [RX_W-1:0] rx_data
);
    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sck == cfg_cpol)); // R3

    AST_SCK_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sck) |-> (!cs_n && !$past(cs_n))); // R2

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6

    AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (cs_n && !$past(cs_n))); // R6

    AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data)); // R10

    AST_OVERRUN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !$past(cs_n)); // R9
endmodule

bind periodic_spi_master pspi_checker #(.RX_W(LANES*WORDS*WORD_W)) u_pspi_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_cpol(cfg_cpol),
    .cs_n    (cs_n),
    .sck     (sck),
    .rx_valid(rx_valid),
    .overrun (overrun),
    .rx_data (rx_data)
);

// File: tb/tb_periodic_spi_master.sv
module tb_periodic_spi_master;
    localparam int LANES = 2;
    localparam int WORDS = 2;
    localparam int WORD_W = 16;
    localparam int STEP = 40;
    localparam int NSTEP = 4;
    localparam int HALF = 2;
    localparam int BITS = WORDS * WORD_W;
    localparam int P = STEP * NSTEP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [7:0] cfg_cs_lead = '0, cfg_clk_delay = '0;
    logic [LANES*BITS-1:0] tx_data = '0;
    logic [LANES-1:0] miso = '0;
    logic sck, cs_n, rx_valid, overrun;
    logic [LANES-1:0] mosi;
    logic [LANES*BITS-1:0] rx_data;

    int compared = 0, mismatched = 0;
    logic peer_cpha = 1'b0;

    always #10 clk = ~clk;

    periodic_spi_master #(
        .LANES(LANES), .WORDS(WORDS), .WORD_W(WORD_W), .STEP_CYCLES(STEP),
        .STEPS_PER_FRAME(NSTEP), .SCK_HALF(HALF), .DLY_W(8)
    ) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_cs_lead(cfg_cs_lead), .cfg_clk_delay(cfg_clk_delay),
        .tx_data(tx_data), .miso(miso), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .rx_data(rx_data), .rx_valid(rx_valid), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [BITS-1:0] peer_word(input int l, input int f);
        return (32'h9A3C_5E71 ^ (32'h0101_1010 * l)) + 32'h0007_3301 * f;
    endfunction

    function automatic logic [LANES*BITS-1:0] tx_gen(input int k);
        return {32'hC3A5_0F1E + 32'h0011_2233 * k, 32'h1E2D_3C4B ^ (32'h0F0F_0101 * k)};
    endfunction

    // ---------------- behavioural reference model ----------------
    int pos = -1;
    int ecnt = 0;
    bit exp_valid = 1'b0, exp_ovr = 1'b0;
    logic [LANES*BITS-1:0] exp_tx = '0;
    logic [LANES*BITS-1:0] held_rx = '0;

    function automatic int frame_len();
        return int'(cfg_cs_lead) + int'(cfg_clk_delay) + 2 + 2 * BITS * HALF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pos = -1; ecnt = 0; exp_valid = 1'b0; exp_ovr = 1'b0;
        end else begin
            bit tk;
            tk = enable && ((ecnt % P) == P - 1);
            exp_valid = 1'b0;
            exp_ovr = tk && (pos != -1);
            if (pos == -1) begin
                if (tk) begin
                    pos = 0;
                    exp_tx = tx_data;
                end
            end else if (pos == frame_len() - 1) begin
                pos = -1;
                exp_valid = 1'b1;
            end else begin
                pos++;
            end
            ecnt = enable ? ecnt + 1 : 0;
        end
    end

    function automatic logic exp_sck();
        int s, e;
        s = int'(cfg_cs_lead) + 1;
        if (pos < s) return cfg_cpol;
        e = (pos - s) / HALF;
        if (e > 2 * BITS) e = 2 * BITS;
        return cfg_cpol ^ logic'(e % 2);
    endfunction

    // ---------------- peer device ----------------
    logic [BITS-1:0] psr[LANES];
    logic [BITS-1:0] prx[LANES];
    int pbit = 0, pf = 0, txk = 0;
    bit pfirst = 1'b1;
    logic prev_cs = 1'b1, prev_sck = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cs = 1'b1; prev_sck = cfg_cpol;
        end else begin
            if (prev_cs && !cs_n) begin
                for (int l = 0; l < LANES; l++) begin
                    psr[l] = peer_word(l, pf);
                    prx[l] = '0;
                    miso[l] = psr[l][BITS-1];
                end
                pbit = 0; pfirst = 1'b1; pf++;
                txk++;
                tx_data = tx_gen(txk);   // R7: mid-frame change
            end else if (!cs_n && sck != prev_sck) begin
                bit lead;
                lead = (sck != cfg_cpol);
                if (lead != peer_cpha) begin
                    for (int l = 0; l < LANES; l++) prx[l] = {prx[l][BITS-2:0], mosi[l]};
                end else if (!peer_cpha || !pfirst) begin
                    pbit++;
                    if (pbit < BITS)
                        for (int l = 0; l < LANES; l++) miso[l] = psr[l][BITS-1-pbit];
                end
                if (lead) pfirst = 1'b0;
            end
            prev_cs = cs_n; prev_sck = sck;
        end
    end

    // ---------------- per-clock comparison ----------------
    bit cmp_on = 1'b0;
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(cs_n == (pos == -1), enable ? "R1 cs_n" : "R11 cs_n idle", cs_n, pos == -1);
            chk(sck == exp_sck(), (pos == -1) ? "R3 sck idle" : "R2 sck", sck, exp_sck());
            chk(rx_valid == exp_valid, "R6 rx_valid", rx_valid, exp_valid);
            chk(overrun == exp_ovr, "R9 overrun", overrun, exp_ovr);
            if (!rx_valid) chk(rx_data == held_rx, "R10 rx held", rx_data, held_rx);
            if (exp_valid && rx_valid) begin
                for (int l = 0; l < LANES; l++) begin
                    if (peer_cpha != cfg_cpha) begin
                        chk(rx_data[l*BITS +: BITS] != peer_word(l, pf - 1), "R8 corrupted",
                            rx_data[l*BITS +: BITS], peer_word(l, pf - 1));
                    end else begin
                        chk(rx_data[l*BITS +: BITS] == peer_word(l, pf - 1), "R5 R6 rx lane",
                            rx_data[l*BITS +: BITS], peer_word(l, pf - 1));
                        chk(prx[l] == exp_tx[l*BITS +: BITS], "R4 R7 mosi lane",
                            prx[l], exp_tx[l*BITS +: BITS]);
                    end
                end
            end
            held_rx = rx_data;
        end
    end

    task automatic run_case(input logic pol, input logic pha, input logic ppha,
                            input int lead, input int dly, input bit en, input int cycles);
        cmp_on = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; enable = 1'b0;
        cfg_cpol = pol; cfg_cpha = pha; peer_cpha = ppha;
        cfg_cs_lead = 8'(lead); cfg_clk_delay = 8'(dly);
        tx_data = tx_gen(txk);
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sck == pol && rx_valid == 1'b0, "R3 reset state", {cs_n, sck, rx_valid}, {1'b1, pol, 1'b0});
        held_rx = rx_data;
        rst_n = 1'b1;
        cmp_on = 1'b1;
        enable = en;
        repeat (cycles) @(negedge clk);
        enable = 1'b0;
        repeat (frame_len() + 4) @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        run_case(1'b0, 1'b0, 1'b0, 3, 2, 1'b1, 3 * P);   // mode 0, R4 R5 R7
        run_case(1'b0, 1'b1, 1'b1, 0, 0, 1'b1, 3 * P);   // mode 1
        run_case(1'b1, 1'b0, 1'b0, 5, 1, 1'b1, 3 * P);   // mode 2
        run_case(1'b1, 1'b1, 1'b1, 1, 4, 1'b1, 3 * P);   // mode 3
        run_case(1'b0, 1'b0, 1'b1, 2, 2, 1'b1, 2 * P);   // R8 phase mismatch
        run_case(1'b0, 1'b0, 1'b0, 20, 20, 1'b1, 4 * P); // R9 frame longer than period
        run_case(1'b0, 1'b0, 1'b0, 3, 2, 1'b0, 3 * P);   // R11 disabled
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule